// File: doc/BRIEF.md
# DMA Descriptor Burst Command Sequencer

This block walks a small table of transfer descriptors and turns each enabled one into a stream of read-burst and write-burst commands for an AXI-style memory fabric. Each command carries a start address, a burst length field (beats minus one) and a burst type code. The block keeps the descriptor table, the control word and the captured error details itself. Software reaches them through a simple indexed write port and a set of read-only status outputs. The data beats, their handshakes and bus-side register decoding live elsewhere.

Software fills the descriptor slots, then writes the control word with the start bit set and the chosen burst cap. The block then visits the slots in ascending order. For each enabled slot it issues one read command followed by one write command of equal length, and repeats this until the slot's byte count is used up. Processing ends with a done flag, an abort, or a captured error. A beat is four bytes.

Top module: `dma_burst_seq`

## Requirements
- R1: After reset the status word reads 0x0000CAFE: version constant 0xCAFE in bits [15:0], done (bit 16) and error (bit 17) clear. The error info reads 0 and busy is low.
- R2: A transfer of N bytes needs ceil(N/4) beats. Each burst has at most cap+1 beats, where cap is control bits [9:2]. The command length field equals beats minus one.
- R3: In incrementing mode, no burst crosses a 4096-byte address boundary on the side that increments.
- R4: In incrementing mode the next burst address on that side advances by 4 times the beats issued, and the burst code is 01. In fixed mode the address stays constant and the burst code is 00.
- R5: Every burst is one read command followed by one write command of the same length. A command's valid stays high, with stable fields, until its ready is seen.
- R6: Slots are visited in index order. A slot whose enable bit is clear generates no commands. Slot config bits: bit 2 enable, bit 1 read fixed, bit 0 write fixed.
- R7: Status done is set only after the last slot has been handled. Done and error are never both set.
- R8: An enabled slot with a byte count of zero raises a configuration error and issues no commands. The error address is the slot's source address, and the error info is {trigger=1, source=0, type=1} in bits [2:0] = {2,1,0}.
- R9: When cap+1 exceeds 16 beats on a slot that uses fixed mode, a configuration error is raised and no commands are issued. A fixed read side takes precedence and reports source 0 with the source address. Otherwise the fixed write side reports source 1 with the destination address.
- R10: A response error while busy captures the error address, type 0, and source 0 for read or 1 for write, sets the trigger, and stops at once with no further commands. A read error wins over a simultaneous write error. An error in the same cycle as a command handshake counts that handshake and then stops.
- R11: Abort (control bit 1) lets the command handshake in progress complete, then issues nothing more and leaves done clear.
- R12: Writing the start bit while busy has no effect on the command sequence.
- R13: A new start clears the done bit and all error fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | IDX_W | Register index: 0 control; 4+4*slot+{0 src,1 dst,2 byte count,3 config} |
| reg_wdata | input | 32 | Write data |
| status_o | output | 32 | {error, done, version} |
| err_addr_o | output | 32 | Captured error address |
| err_info_o | output | 3 | {trigger, source, type} |
| busy_o | output | 1 | Sequencer active |
| rd_cmd_valid | output | 1 | Read command valid |
| rd_cmd_ready | input | 1 | Read command accepted |
| rd_cmd_addr | output | 32 | Read burst address |
| rd_cmd_len | output | 8 | Read beats minus one |
| rd_cmd_burst | output | 2 | 00 fixed, 01 incrementing |
| wr_cmd_valid | output | 1 | Write command valid |
| wr_cmd_ready | input | 1 | Write command accepted |
| wr_cmd_addr | output | 32 | Write burst address |
| wr_cmd_len | output | 8 | Write beats minus one |
| wr_cmd_burst | output | 2 | 00 fixed, 01 incrementing |
| rd_err_i | input | 1 | Read response error pulse |
| rd_err_addr_i | input | 32 | Address of failing read |
| wr_err_i | input | 1 | Write response error pulse |
| wr_err_addr_i | input | 32 | Address of failing write |

## Verification
Two pairs of events can land on the same edge: a response error and a command handshake, and an abort request and a pending command. For the first pair, the bench holds ready high, waits for a read command (and in a second case a write command) to become valid, and raises the error pulse in that very cycle. The scoreboard must then see exactly that one handshake and no later command, with the error fields naming the right direction. For the second pair, ready is held low while abort is written. When ready is released, the single stalled read must be accepted, no write must follow, and done must stay clear.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
    localparam int AW = 32;
    localparam logic [15:0] REV_ID = 16'hCAFE;
    localparam logic [1:0] BT_FIXED = 2'b00;
    localparam logic [1:0] BT_INCR  = 2'b01;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_PLAN,
        ST_RD,
        ST_WR
    } seq_state_e;

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [AW-1:0] nbytes;
        logic          en;
        logic          rd_fixed;
        logic          wr_fixed;
    } slot_t;
endpackage

// File: rtl/dma_slot_regs.sv
module dma_slot_regs
    import dma_seq_pkg::*;
#(
    parameter int NUM_SLOTS = 2,
    parameter int IDX_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    output slot_t            slots_o [NUM_SLOTS],
    output logic [7:0]       max_burst_o,
    output logic             go_o,
    output logic             abort_o
);
    typedef struct packed {
        slot_t [NUM_SLOTS-1:0] slot;
        logic [7:0]            mb;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (wr_idx == '0) r_d.mb = wr_data[9:2];
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (wr_idx == IDX_W'(4 * s + 4)) r_d.slot[s].src    = wr_data;
                if (wr_idx == IDX_W'(4 * s + 5)) r_d.slot[s].dst    = wr_data;
                if (wr_idx == IDX_W'(4 * s + 6)) r_d.slot[s].nbytes = wr_data;
                if (wr_idx == IDX_W'(4 * s + 7)) begin
                    r_d.slot[s].wr_fixed = wr_data[0];
                    r_d.slot[s].rd_fixed = wr_data[1];
                    r_d.slot[s].en       = wr_data[2];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.mb   <= 8'hFF;
        end else begin
            r_q <= r_d;
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_out
        assign slots_o[g] = r_q.slot[g];
    end

    assign max_burst_o = r_q.mb;
    assign go_o        = wr_en && (wr_idx == '0) && wr_data[0];
    assign abort_o     = wr_en && (wr_idx == '0) && wr_data[1];
endmodule

// File: rtl/dma_burst_calc.sv
module dma_burst_calc
    import dma_seq_pkg::*;
#(
    parameter int BEAT_LG = 2,
    parameter int PAGE_LG = 12,
    parameter int REM_W   = AW - BEAT_LG
) (
    input  logic [REM_W-1:0] rem_i,
    input  logic [AW-1:0]    src_i,
    input  logic [AW-1:0]    dst_i,
    input  logic             rd_fixed_i,
    input  logic             wr_fixed_i,
    input  logic [7:0]       max_burst_i,
    output logic [8:0]       beats_o
);
    logic [AW-1:0] lim;
    logic [AW-1:0] room_src;
    logic [AW-1:0] room_dst;

    function automatic logic [AW-1:0] room(input logic [AW-1:0] a);
        room = ((AW'(1) << PAGE_LG) - AW'(a[PAGE_LG-1:0])) >> BEAT_LG;
    endfunction

    always_comb begin
        room_src = room(src_i);
        room_dst = room(dst_i);
        lim = AW'(max_burst_i) + AW'(1);
        if (AW'(rem_i) < lim) lim = AW'(rem_i);
        if (!rd_fixed_i && room_src < lim) lim = room_src;
        if (!wr_fixed_i && room_dst < lim) lim = room_dst;
        beats_o = lim[8:0];
    end
endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq
    import dma_seq_pkg::*;
#(
    parameter int NUM_SLOTS = 2,
    parameter int BEAT_LG   = 2,
    parameter int PAGE_LG   = 12,
    parameter int FIXED_MAX = 16,
    parameter int IDX_W     = $clog2(4 + 4 * NUM_SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      status_o,
    output logic [31:0]      err_addr_o,
    output logic [2:0]       err_info_o,
    output logic             busy_o,
    output logic             rd_cmd_valid,
    input  logic             rd_cmd_ready,
    output logic [31:0]      rd_cmd_addr,
    output logic [7:0]       rd_cmd_len,
    output logic [1:0]       rd_cmd_burst,
    output logic             wr_cmd_valid,
    input  logic             wr_cmd_ready,
    output logic [31:0]      wr_cmd_addr,
    output logic [7:0]       wr_cmd_len,
    output logic [1:0]       wr_cmd_burst,
    input  logic             rd_err_i,
    input  logic [31:0]      rd_err_addr_i,
    input  logic             wr_err_i,
    input  logic [31:0]      wr_err_addr_i
);
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam int REM_W  = AW - BEAT_LG;

    typedef struct packed {
        seq_state_e        st;
        logic [SLOT_W-1:0] slot;
        logic [AW-1:0]     cur_src;
        logic [AW-1:0]     cur_dst;
        logic [REM_W-1:0]  rem;
        logic [8:0]        beats;
        logic              rd_fx;
        logic              wr_fx;
        logic              abort_pend;
        logic              done;
        logic              etrig;
        logic              etype;
        logic              esrc;
        logic [AW-1:0]     eaddr;
    } seq_t;

    seq_t  s_d, s_q;
    slot_t slots [NUM_SLOTS];
    slot_t cs;
    logic [7:0] mb;
    logic go_pulse, abort_pulse, abort_now, too_long;
    logic [8:0] calc_beats;

    dma_slot_regs #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_idx(reg_idx),
        .wr_data(reg_wdata), .slots_o(slots), .max_burst_o(mb),
        .go_o(go_pulse), .abort_o(abort_pulse)
    );

    dma_burst_calc #(.BEAT_LG(BEAT_LG), .PAGE_LG(PAGE_LG), .REM_W(REM_W)) u_calc (
        .rem_i(s_q.rem), .src_i(s_q.cur_src), .dst_i(s_q.cur_dst),
        .rd_fixed_i(s_q.rd_fx), .wr_fixed_i(s_q.wr_fx),
        .max_burst_i(mb), .beats_o(calc_beats)
    );

    function automatic seq_t next_slot(input seq_t x);
        seq_t y = x;
        if (x.slot == SLOT_W'(NUM_SLOTS - 1)) begin
            y.done = 1'b1;
            y.st   = ST_IDLE;
        end else begin
            y.slot = x.slot + 1'b1;
            y.st   = ST_CHECK;
        end
        return y;
    endfunction

    always_comb begin
        s_d       = s_q;
        cs        = slots[s_q.slot];
        abort_now = s_q.abort_pend | abort_pulse;
        too_long  = ({1'b0, mb} >= 9'(FIXED_MAX));
        if (s_q.st != ST_IDLE && abort_pulse) s_d.abort_pend = 1'b1;
        case (s_q.st)
            ST_IDLE: begin
                if (go_pulse) begin
                    s_d.st         = ST_CHECK;
                    s_d.slot       = '0;
                    s_d.done       = 1'b0;
                    s_d.etrig      = 1'b0;
                    s_d.etype      = 1'b0;
                    s_d.esrc       = 1'b0;
                    s_d.eaddr      = '0;
                    s_d.abort_pend = 1'b0;
                end
            end
            ST_CHECK: begin
                if (abort_now) begin
                    s_d.st = ST_IDLE;
                end else if (!cs.en) begin
                    s_d = next_slot(s_d);
                end else if (cs.nbytes == '0 || (cs.rd_fixed && too_long)) begin
                    s_d.st    = ST_IDLE;
                    s_d.etrig = 1'b1;
                    s_d.etype = 1'b1;
                    s_d.esrc  = 1'b0;
                    s_d.eaddr = cs.src;
                end else if (cs.wr_fixed && too_long) begin
                    s_d.st    = ST_IDLE;
                    s_d.etrig = 1'b1;
                    s_d.etype = 1'b1;
                    s_d.esrc  = 1'b1;
                    s_d.eaddr = cs.dst;
                end else begin
                    s_d.cur_src = cs.src;
                    s_d.cur_dst = cs.dst;
                    s_d.rd_fx   = cs.rd_fixed;
                    s_d.wr_fx   = cs.wr_fixed;
                    s_d.rem     = cs.nbytes[AW-1:BEAT_LG]
                                + REM_W'(|cs.nbytes[BEAT_LG-1:0]);
                    s_d.st      = ST_PLAN;
                end
            end
            ST_PLAN: begin
                if (abort_now) begin
                    s_d.st = ST_IDLE;
                end else begin
                    s_d.beats = calc_beats;
                    s_d.st    = ST_RD;
                end
            end
            ST_RD: begin
                if (rd_cmd_ready) s_d.st = abort_now ? ST_IDLE : ST_WR;
            end
            ST_WR: begin
                if (wr_cmd_ready) begin
                    if (!s_q.rd_fx) s_d.cur_src = s_q.cur_src + (AW'(s_q.beats) << BEAT_LG);
                    if (!s_q.wr_fx) s_d.cur_dst = s_q.cur_dst + (AW'(s_q.beats) << BEAT_LG);
                    s_d.rem = s_q.rem - REM_W'(s_q.beats);
                    if (abort_now) s_d.st = ST_IDLE;
                    else if (s_q.rem == REM_W'(s_q.beats)) s_d = next_slot(s_d);
                    else s_d.st = ST_PLAN;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
        if (s_q.st != ST_IDLE && (rd_err_i || wr_err_i)) begin
            s_d.st    = ST_IDLE;
            s_d.done  = 1'b0;
            s_d.etrig = 1'b1;
            s_d.etype = 1'b0;
            s_d.esrc  = !rd_err_i;
            s_d.eaddr = rd_err_i ? rd_err_addr_i : wr_err_addr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o       = (s_q.st != ST_IDLE);
    assign status_o     = {14'b0, s_q.etrig, s_q.done, REV_ID};
    assign err_addr_o   = s_q.eaddr;
    assign err_info_o   = {s_q.etrig, s_q.esrc, s_q.etype};
    assign rd_cmd_valid = (s_q.st == ST_RD);
    assign rd_cmd_addr  = s_q.cur_src;
    assign rd_cmd_len   = 8'(s_q.beats - 9'd1);
    assign rd_cmd_burst = s_q.rd_fx ? BT_FIXED : BT_INCR;
    assign wr_cmd_valid = (s_q.st == ST_WR);
    assign wr_cmd_addr  = s_q.cur_dst;
    assign wr_cmd_len   = 8'(s_q.beats - 9'd1);
    assign wr_cmd_burst = s_q.wr_fx ? BT_FIXED : BT_INCR;

    // R5
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd_valid && !rd_cmd_ready && !rd_err_i && !wr_err_i
        |=> rd_cmd_valid && $stable(rd_cmd_addr) && $stable(rd_cmd_len));
    // R2
    len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd_valid |-> rd_cmd_len <= mb);
    // R3
    page_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd_valid && rd_cmd_burst == BT_INCR
        |-> (32'(rd_cmd_addr[PAGE_LG-1:0]) + ((32'(rd_cmd_len) + 32'd1) << BEAT_LG))
            <= (32'd1 << PAGE_LG));
    // R9
    fixed_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd_valid && wr_cmd_burst == BT_FIXED |-> 32'(wr_cmd_len) < 32'(FIXED_MAX));
    // R7
    done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(status_o[16] && status_o[17]));
    // R10
    err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && (rd_err_i || wr_err_i) |=> !busy_o && err_info_o[2]);
endmodule

// File: tb/tb_dma_burst_seq.sv
module tb_dma_burst_seq;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        dir;
        logic [31:0] addr;
        logic [7:0]  len;
        logic [1:0]  burst;
    } cmd_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [3:0] reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] status_o, err_addr_o;
    logic [2:0] err_info_o;
    logic busy_o;
    logic rd_cmd_valid, rd_cmd_ready, wr_cmd_valid, wr_cmd_ready;
    logic [31:0] rd_cmd_addr, wr_cmd_addr;
    logic [7:0] rd_cmd_len, wr_cmd_len;
    logic [1:0] rd_cmd_burst, wr_cmd_burst;
    logic rd_err_i = 1'b0, wr_err_i = 1'b0;
    logic [31:0] rd_err_addr_i = '0, wr_err_addr_i = '0;

    logic hold = 1'b0, stall_en = 1'b0;
    logic [7:0] lfsr = 8'h5A;
    int total = 0, bad = 0;
    cmd_t exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    assign rd_cmd_ready = !hold && (!stall_en || lfsr[0]);
    assign wr_cmd_ready = !hold && (!stall_en || lfsr[1]);

    dma_burst_seq dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .status_o(status_o), .err_addr_o(err_addr_o),
        .err_info_o(err_info_o), .busy_o(busy_o),
        .rd_cmd_valid(rd_cmd_valid), .rd_cmd_ready(rd_cmd_ready),
        .rd_cmd_addr(rd_cmd_addr), .rd_cmd_len(rd_cmd_len), .rd_cmd_burst(rd_cmd_burst),
        .wr_cmd_valid(wr_cmd_valid), .wr_cmd_ready(wr_cmd_ready),
        .wr_cmd_addr(wr_cmd_addr), .wr_cmd_len(wr_cmd_len), .wr_cmd_burst(wr_cmd_burst),
        .rd_err_i(rd_err_i), .rd_err_addr_i(rd_err_addr_i),
        .wr_err_i(wr_err_i), .wr_err_addr_i(wr_err_addr_i)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic see_cmd(input cmd_t got);
        cmd_t e;
        total++;
        if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL R5/R6 unexpected cmd act=%h exp=none", got);
        end else begin
            e = exp_q.pop_front();
            if (got !== e) begin
                bad++;
                $display("FAIL R2/R3/R4/R5 cmd act=%h exp=%h", got, e);
            end
        end
    endtask

    // monitor: the scoreboard consumer
    always @(negedge clk) begin
        if (rst_n && rd_cmd_valid && rd_cmd_ready)
            see_cmd({1'b0, rd_cmd_addr, rd_cmd_len, rd_cmd_burst});
        if (rst_n && wr_cmd_valid && wr_cmd_ready)
            see_cmd({1'b1, wr_cmd_addr, wr_cmd_len, wr_cmd_burst});
    end

    task automatic wr_reg(input int idx, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_idx = 4'(idx); reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic set_slot(input int s, input logic [31:0] src, input logic [31:0] dst,
                            input logic [31:0] n, input logic [2:0] cfg);
        wr_reg(4 + 4 * s, src);
        wr_reg(5 + 4 * s, dst);
        wr_reg(6 + 4 * s, n);
        wr_reg(7 + 4 * s, {29'b0, cfg});
    endtask

    // driver: expected command stream from the requirements
    task automatic push_xfer(input logic [31:0] src_in, input logic [31:0] dst_in,
                             input logic [31:0] n, input logic [2:0] cfg, input int mb);
        int rem, b, room;
        logic [31:0] src, dst;
        logic rfx, wfx;
        if (!cfg[2]) return;
        src = src_in; dst = dst_in;
        rfx = cfg[1]; wfx = cfg[0];
        rem = int'(n >> 2) + ((n[1:0] != 0) ? 1 : 0);
        while (rem > 0) begin
            b = mb + 1;
            if (rem < b) b = rem;
            if (!rfx) begin room = (4096 - int'(src[11:0])) / 4; if (room < b) b = room; end
            if (!wfx) begin room = (4096 - int'(dst[11:0])) / 4; if (room < b) b = room; end
            exp_q.push_back({1'b0, src, 8'(b - 1), rfx ? 2'b00 : 2'b01});
            exp_q.push_back({1'b1, dst, 8'(b - 1), wfx ? 2'b00 : 2'b01});
            if (!rfx) src = src + 32'(b * 4);
            if (!wfx) dst = dst + 32'(b * 4);
            rem = rem - b;
        end
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy_o && n < 20000) begin
            @(posedge clk); #1; n++;
        end
        chk("R7 returns idle", {31'b0, busy_o}, 32'd0);
    endtask

    task automatic go(input int mb);
        wr_reg(0, 32'(mb << 2) | 32'd1);
    endtask

    task automatic q_empty(input string tag);
        chk(tag, 32'(exp_q.size()), 32'd0);
        exp_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        chk("R1 status reset", status_o, 32'h0000CAFE);
        chk("R1 err info reset", {29'b0, err_info_o}, 32'd0);
        chk("R1 busy reset", {31'b0, busy_o}, 32'd0);

        // R2: 512 beats under cap 255 -> two full bursts, slot 1 disabled (R6)
        set_slot(0, 32'h0000_1000, 32'h0000_8000, 32'd2048, 3'b100);
        set_slot(1, 32'h0000_5000, 32'h0000_6000, 32'd64, 3'b000);
        push_xfer(32'h0000_1000, 32'h0000_8000, 32'd2048, 3'b100, 255);
        go(255);
        wait_idle();
        q_empty("R2 R6 all bursts seen");
        chk("R7 done set", {31'b0, status_o[16]}, 32'd1);

        // R3 R4: page split, odd byte count, cap 7, slot 1 fixed write
        stall_en = 1'b1;
        set_slot(0, 32'h0000_0FF0, 32'h0000_2000, 32'd70, 3'b100);
        set_slot(1, 32'h0000_3000, 32'h0000_9000, 32'd40, 3'b101);
        push_xfer(32'h0000_0FF0, 32'h0000_2000, 32'd70, 3'b100, 7);
        push_xfer(32'h0000_3000, 32'h0000_9000, 32'd40, 3'b101, 7);
        go(7);
        wait_idle();
        q_empty("R3 R4 split sequence");
        chk("R7 done after both", status_o, 32'h0001CAFE);

        // R6: slot 0 disabled, slot 1 read fixed, cap 3
        set_slot(0, 32'h0000_7000, 32'h0000_7800, 32'd32, 3'b000);
        set_slot(1, 32'h0000_4000, 32'h0000_4FF8, 32'd36, 3'b110);
        push_xfer(32'h0000_4000, 32'h0000_4FF8, 32'd36, 3'b110, 3);
        go(3);
        wait_idle();
        q_empty("R6 skip disabled slot");

        // R8: zero byte count
        set_slot(0, 32'h0000_ABC0, 32'h0000_1234, 32'd0, 3'b100);
        go(3);
        wait_idle();
        q_empty("R8 no commands");
        chk("R8 err addr", err_addr_o, 32'h0000_ABC0);
        chk("R8 err info", {29'b0, err_info_o}, 32'd5);
        chk("R8 status err no done", status_o, 32'h0002CAFE);

        // R9: fixed write with cap 31
        set_slot(0, 32'h0000_1100, 32'h0000_2200, 32'd64, 3'b101);
        go(31);
        wait_idle();
        q_empty("R9 no commands");
        chk("R9 err addr dst", err_addr_o, 32'h0000_2200);
        chk("R9 err info", {29'b0, err_info_o}, 32'd7);

        // R13: fresh start clears error and re-runs cleanly
        set_slot(0, 32'h0000_1000, 32'h0000_2000, 32'd16, 3'b100);
        set_slot(1, 32'h0000_3000, 32'h0000_4000, 32'd16, 3'b000);
        push_xfer(32'h0000_1000, 32'h0000_2000, 32'd16, 3'b100, 31);
        go(31);
        chk("R13 err cleared on start", {29'b0, err_info_o}, 32'd0);
        wait_idle();
        q_empty("R13 run after error");
        chk("R13 status", status_o, 32'h0001CAFE);

        // R10: read error in the same cycle as the first read handshake
        stall_en = 1'b0;
        set_slot(0, 32'h0001_0000, 32'h0002_0000, 32'd256, 3'b100);
        exp_q.push_back({1'b0, 32'h0001_0000, 8'd7, 2'b01});
        go(7);
        chk("R13 done cleared on start", {31'b0, status_o[16]}, 32'd0);
        while (!rd_cmd_valid) begin @(posedge clk); #1; end
        rd_err_i = 1'b1; rd_err_addr_i = 32'hDEAD_0000;
        @(posedge clk); #1;
        rd_err_i = 1'b0;
        repeat (5) @(posedge clk); #1;
        q_empty("R10 stop after read error");
        chk("R10 read err info", {29'b0, err_info_o}, 32'd4);
        chk("R10 read err addr", err_addr_o, 32'hDEAD_0000);
        chk("R10 no done", status_o, 32'h0002CAFE);

        // R10: write error together with a read error pulse absent, on write handshake
        exp_q.push_back({1'b0, 32'h0001_0000, 8'd7, 2'b01});
        exp_q.push_back({1'b1, 32'h0002_0000, 8'd7, 2'b01});
        go(7);
        while (!wr_cmd_valid) begin @(posedge clk); #1; end
        wr_err_i = 1'b1; wr_err_addr_i = 32'hBEEF_0040;
        @(posedge clk); #1;
        wr_err_i = 1'b0;
        repeat (5) @(posedge clk); #1;
        q_empty("R10 stop after write error");
        chk("R10 write err info", {29'b0, err_info_o}, 32'd6);
        chk("R10 write err addr", err_addr_o, 32'hBEEF_0040);

        // R11: abort while the read command is stalled
        hold = 1'b1;
        exp_q.push_back({1'b0, 32'h0001_0000, 8'd7, 2'b01});
        go(7);
        while (!rd_cmd_valid) begin @(posedge clk); #1; end
        wr_reg(0, 32'(7 << 2) | 32'd2);
        chk("R11 still waiting", {31'b0, rd_cmd_valid}, 32'd1);
        hold = 1'b0;
        repeat (6) @(posedge clk); #1;
        q_empty("R11 one handshake then stop");
        chk("R11 idle no done", {30'b0, status_o[17:16]}, 32'd0);
        chk("R11 not busy", {31'b0, busy_o}, 32'd0);

        // R12: start written again mid-run
        stall_en = 1'b1;
        push_xfer(32'h0001_0000, 32'h0002_0000, 32'd256, 3'b100, 7);
        go(7);
        repeat (10) @(posedge clk); #1;
        go(7);
        wait_idle();
        q_empty("R12 sequence unchanged");
        chk("R12 done", status_o, 32'h0001CAFE);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule